// File: doc/BRIEF.md
# Flash Fetch Wait-State Controller

This block sits between the instruction-fetch port of a processor and a synchronous flash read port. It turns each accepted fetch into a flash read strobe. The read is then stretched by zero or one wait-state, as a 2-bit mode register selects. Only one read is in flight at a time, and the requester sees a not-ready signal while a read cannot be accepted.

A fetch tagged as a speculative branch target can be held back to save energy. With suppression enabled, such a fetch is accepted but parked in a single pending slot, and no flash read takes place. A later branch-resolve strobe decides its fate. When the branch is taken, the parked address is issued as an ordinary fetch and its data returns like any other. When it is not taken, the parked address is discarded without touching the flash. A 16-bit access counter, counting flash read strobes, lets a bench measure the reads that suppression saves.

Top module: `fetch_ws_ctrl`

## Requirements
- R1: After reset, `cfg_mode_o` reads 2'b01 (one wait-state, no suppression), `acc_cnt_o` is 0, `rsp_valid_o` is 0 and `req_ready_o` is 1.
- R2: A write with `cfg_we_i`=1 loads `cfg_wdata_i` into the mode register, which is visible on `cfg_mode_o` from the next cycle. Bit 0 set selects one wait-state. Bit 1 set enables branch-target suppression.
- R3: With mode bit 0 clear, an accepted non-suppressed fetch in cycle T raises `fl_rd_o` with `fl_addr_o` equal to the fetch address in cycle T. `rsp_valid_o` is then 1 in cycle T+1, with `rsp_data_o` equal to the flash data for that address. Fetches can be accepted in back-to-back cycles.
- R4: With mode bit 0 set, an accepted fetch in cycle T gives `rsp_valid_o`=0 in T+1 and `rsp_valid_o`=1 in T+2. The flash data is returned in T+2.
- R5: With suppression off, a fetch with `req_spec_i`=1 is read from flash at once, like a sequential fetch, and it counts as an access.
- R6: With suppression on, a fetch with `req_spec_i`=1 is accepted (`req_ready_o`=1) without raising `fl_rd_o`, and its address is held pending.
- R7: A resolve strobe with `rsv_taken_i`=1 while a target is pending issues that target on `fl_rd_o`/`fl_addr_o` in the cycle after the strobe. This issue takes priority over a new request, which sees `req_ready_o`=0 in that cycle. The target's data is then returned.
- R8: A resolve strobe with `rsv_taken_i`=0 while a target is pending drops it. No flash read occurs for it, and `acc_cnt_o` does not change.
- R9: The wait-state count of a read is fixed by the mode at the cycle the read is issued. A mode write during a read affects only later reads.
- R10: `acc_cnt_o` increases by one in the cycle after each cycle in which `fl_rd_o` is 1, and otherwise holds. It wraps modulo 2^16.
- R11: At most one read is outstanding. During the wait-state cycle `req_ready_o` is 0 and `fl_rd_o` is 0. While a target is pending, a further suppressed target request sees `req_ready_o`=0.
- R12: A resolve strobe with no target pending has no effect: no flash read, and no change of `acc_cnt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Fetch request valid |
| req_addr_i | input | ADDR_W | Fetch address |
| req_spec_i | input | 1 | 1 = speculative branch-target fetch, 0 = sequential |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| rsv_valid_i | input | 1 | Branch-resolve strobe |
| rsv_taken_i | input | 1 | Branch taken flag, qualified by rsv_valid_i |
| cfg_we_i | input | 1 | Mode register write enable |
| cfg_wdata_i | input | 2 | Mode register write data |
| cfg_mode_o | output | 2 | Current mode register value |
| fl_rd_o | output | 1 | Flash read strobe |
| fl_addr_o | output | ADDR_W | Flash read address |
| fl_rdata_i | input | DATA_W | Flash read data, registered by the flash |
| rsp_valid_o | output | 1 | Returned data valid |
| rsp_data_o | output | DATA_W | Returned fetch data |
| acc_cnt_o | output | CNT_W | Flash read strobe counter |

## Verification
A corrupted sequencer state shows up within one or two cycles. It appears as a response arriving a cycle early or late against the latency the issue-time mode predicts, as data that belongs to the wrong address, or as a request accepted in the wait-state cycle. A wrong pending-slot state is silent until the resolve strobe. From then on it appears as a read strobe after a not-taken branch, a missing strobe after a taken one, or an access count that differs from the count of strobes. The scoreboard matches every response against the address order of the accepted fetches, so an extra, lost or reordered read is reported at the response where it occurs.

// File: rtl/fws_pkg.sv
package fws_pkg;
  localparam int unsigned MODE_W   = 2;
  localparam int unsigned MODE_WS  = 0;
  localparam int unsigned MODE_SUP = 1;
  localparam logic [MODE_W-1:0] MODE_RST = 2'b01;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_DATA = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_HOLD = 2'd1,
    PEND_GO   = 2'd2
  } pend_state_e;
endpackage

// File: rtl/fws_mode_reg.sv
module fws_mode_reg
  import fws_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MODE_W-1:0] wdata_i,
  output logic [MODE_W-1:0] mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_o <= MODE_RST;
    else if (we_i) mode_o <= wdata_i;
  end

  // R2
  mode_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mode_o == $past(wdata_i));
  // R2
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mode_o));
endmodule

// File: rtl/fws_branch_hold.sv
module fws_branch_hold
  import fws_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] cap_addr_i,
  input  logic              rsv_valid_i,
  input  logic              rsv_taken_i,
  input  logic              fire_i,
  output logic              busy_o,
  output logic              go_o,
  output logic [ADDR_W-1:0] addr_o
);
  pend_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PEND_NONE: if (cap_i) st_d = PEND_HOLD;
      PEND_HOLD: if (rsv_valid_i) st_d = rsv_taken_i ? PEND_GO : PEND_NONE;
      PEND_GO:   if (fire_i) st_d = PEND_NONE;
      default:   st_d = PEND_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PEND_NONE;
      addr_o <= '0;
    end else begin
      st_q <= st_d;
      if (cap_i && st_q == PEND_NONE) addr_o <= cap_addr_i;
    end
  end

  assign busy_o = (st_q != PEND_NONE);
  assign go_o   = (st_q == PEND_GO);

  // R8
  drop_on_not_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !go_o && rsv_valid_i && !rsv_taken_i) |=> !busy_o);
  // R7
  go_on_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !go_o && rsv_valid_i && rsv_taken_i) |=> go_o && $stable(addr_o));
  // R12
  idle_resolve_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !cap_i) |=> !busy_o);
endmodule

// File: rtl/fws_read_seq.sv
module fws_read_seq
  import fws_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ws_i,
  input  logic [DATA_W-1:0] fl_rdata_i,
  output logic              slot_free_o,
  output logic              fl_rd_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [CNT_W-1:0]  acc_cnt_o
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_IDLE, SEQ_DATA: begin
        if (issue_i) st_d = ws_i ? SEQ_WAIT : SEQ_DATA;
        else         st_d = SEQ_IDLE;
      end
      SEQ_WAIT: st_d = SEQ_DATA;
      default:  st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= SEQ_IDLE;
      acc_cnt_o <= '0;
    end else begin
      st_q <= st_d;
      if (fl_rd_o) acc_cnt_o <= acc_cnt_o + 1'b1;
    end
  end

  assign slot_free_o = (st_q != SEQ_WAIT);
  assign fl_rd_o     = issue_i;
  assign fl_addr_o   = addr_i;
  assign rsp_valid_o = (st_q == SEQ_DATA);
  assign rsp_data_o  = fl_rdata_i;

  // R11
  single_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> slot_free_o);
  // R3
  zero_wait_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !ws_i) |=> rsp_valid_o);
  // R4
  one_wait_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && ws_i) |=> !rsp_valid_o ##1 rsp_valid_o);
  // R10
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_rd_o |=> acc_cnt_o == CNT_W'($past(acc_cnt_o) + 1'b1));
  // R10
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_rd_o |=> $stable(acc_cnt_o));
endmodule

// File: rtl/fetch_ws_ctrl.sv
module fetch_ws_ctrl
  import fws_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_spec_i,
  output logic              req_ready_o,
  input  logic              rsv_valid_i,
  input  logic              rsv_taken_i,
  input  logic              cfg_we_i,
  input  logic [MODE_W-1:0] cfg_wdata_i,
  output logic [MODE_W-1:0] cfg_mode_o,
  output logic              fl_rd_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  input  logic [DATA_W-1:0] fl_rdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [CNT_W-1:0]  acc_cnt_o
);
  logic              req_sup, hold_busy, hold_go, slot_free, fire, cap, issue;
  logic [ADDR_W-1:0] hold_addr, issue_addr;

  fws_mode_reg u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .mode_o  (cfg_mode_o)
  );

  assign req_sup = req_spec_i & cfg_mode_o[MODE_SUP];
  assign fire    = hold_go & slot_free;
  assign cap     = req_valid_i & req_sup & ~hold_busy;
  // a released target outranks new requests
  assign req_ready_o = req_sup ? ~hold_busy : (slot_free & ~hold_go);
  assign issue       = fire | (req_valid_i & ~req_sup & slot_free & ~hold_go);
  assign issue_addr  = fire ? hold_addr : req_addr_i;

  fws_branch_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_i       (cap),
    .cap_addr_i  (req_addr_i),
    .rsv_valid_i (rsv_valid_i),
    .rsv_taken_i (rsv_taken_i),
    .fire_i      (fire),
    .busy_o      (hold_busy),
    .go_o        (hold_go),
    .addr_o      (hold_addr)
  );

  fws_read_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (issue),
    .addr_i      (issue_addr),
    .ws_i        (cfg_mode_o[MODE_WS]),
    .fl_rdata_i  (fl_rdata_i),
    .slot_free_o (slot_free),
    .fl_rd_o     (fl_rd_o),
    .fl_addr_o   (fl_addr_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o),
    .acc_cnt_o   (acc_cnt_o)
  );

  // R6
  suppress_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_sup && !hold_go) |-> !fl_rd_o);
  // R7
  release_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_go && slot_free) |-> (fl_rd_o && fl_addr_o == hold_addr && !req_ready_o) || req_sup);
  // R5
  spec_direct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_spec_i && !cfg_mode_o[MODE_SUP]) |-> fl_rd_o);
endmodule

// File: tb/sim_fetch_ws_ctrl.sv
`timescale 1ns/1ps
module sim_fetch_ws_ctrl;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid = 1'b0, req_spec = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          rsv_valid = 1'b0, rsv_taken = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_wdata = '0, cfg_mode;
  logic          fl_rd;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_rdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [CW-1:0] acc_cnt;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] exp_q[$];

  always #10 clk = ~clk;

  fetch_ws_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_spec_i(req_spec),
    .req_ready_o(req_ready),
    .rsv_valid_i(rsv_valid), .rsv_taken_i(rsv_taken),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_mode_o(cfg_mode),
    .fl_rd_o(fl_rd), .fl_addr_o(fl_addr), .fl_rdata_i(fl_rdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .acc_cnt_o(acc_cnt)
  );

  function automatic logic [DW-1:0] fdat(logic [AW-1:0] a);
    return {~a, a};
  endfunction

  // synchronous flash: data registered on the read strobe, then held
  always @(posedge clk) if (fl_rd) fl_rdata <= fdat(fl_addr);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // monitor: responses against scoreboard, sampled mid-cycle
  initial forever begin
    @(negedge clk); #5;
    if (rst_ni && rsp_valid) begin
      if (exp_q.size() == 0) chk("R8 unexpected response", rsp_data, 32'hx);
      else chk("R3 response data", rsp_data, exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    summary();
    $finish;
  end

  // all tasks start and end at a falling edge
  task automatic set_mode(logic [1:0] m);
    cfg_we = 1'b1; cfg_wdata = m;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic do_req(logic [AW-1:0] a, logic spec, bit will_read);
    req_valid = 1'b1; req_addr = a; req_spec = spec;
    forever begin
      #5;
      if (req_ready) begin
        if (will_read) exp_q.push_back(fdat(a));
        break;
      end
      @(negedge clk);
    end
    @(negedge clk); req_valid = 1'b0; req_spec = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [CW-1:0] c0;
    bit all_rd;
    idle(3);
    rst_ni = 1'b1;
    #5;
    chk("R1 reset mode", cfg_mode, 2'b01);
    chk("R1 reset counter", acc_cnt, 0);
    chk("R1 reset rsp_valid", rsp_valid, 0);
    chk("R1 reset ready", req_ready, 1);

    // R2 / R3: zero wait-state
    @(negedge clk); set_mode(2'b00); #5;
    chk("R2 mode written", cfg_mode, 2'b00);
    c0 = acc_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h0100; exp_q.push_back(fdat(16'h0100)); #5;
    chk("R3 strobe same cycle", fl_rd, 1);
    chk("R3 strobe address", fl_addr, 16'h0100);
    @(negedge clk); req_valid = 1'b0; #5;
    chk("R3 data after one cycle", rsp_valid, 1);
    chk("R10 count one read", acc_cnt, c0 + 1);

    // R3: back-to-back zero-wait reads
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      req_valid = 1'b1; req_addr = 16'h0200 + 16'(i);
      exp_q.push_back(fdat(16'h0200 + 16'(i))); #5;
      chk("R3 back-to-back strobe", fl_rd, 1);
      @(negedge clk);
    end
    req_valid = 1'b0;
    idle(2);

    // R4 / R11: one wait-state, second request held off
    set_mode(2'b01);
    req_valid = 1'b1; req_addr = 16'h0300; exp_q.push_back(fdat(16'h0300)); #5;
    chk("R4 strobe", fl_rd, 1);
    @(negedge clk); req_addr = 16'h0301; #5;
    chk("R4 no data in wait cycle", rsp_valid, 0);
    chk("R11 not ready in wait cycle", req_ready, 0);
    chk("R11 no strobe in wait cycle", fl_rd, 0);
    @(negedge clk); #5;
    chk("R4 data after two cycles", rsp_valid, 1);
    chk("R11 ready again", req_ready, 1);
    exp_q.push_back(fdat(16'h0301));
    @(negedge clk); req_valid = 1'b0;
    idle(3);

    // R9: mode write during a one-wait read
    req_valid = 1'b1; req_addr = 16'h0400; exp_q.push_back(fdat(16'h0400)); #5;
    chk("R9 strobe", fl_rd, 1);
    @(negedge clk); req_valid = 1'b0; cfg_we = 1'b1; cfg_wdata = 2'b00; #5;
    chk("R9 old latency kept", rsp_valid, 0);
    @(negedge clk); cfg_we = 1'b0; #5;
    chk("R9 data at old latency", rsp_valid, 1);
    chk("R2 mode updated", cfg_mode, 2'b00);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h0401; cfg_we = 1'b1; cfg_wdata = 2'b01;
    exp_q.push_back(fdat(16'h0401)); #5;
    chk("R9 strobe new access", fl_rd, 1);
    @(negedge clk); req_valid = 1'b0; cfg_we = 1'b0; #5;
    chk("R9 zero-wait applied at issue", rsp_valid, 1);
    idle(2);

    // R5 / R12: suppression off, branch costs two reads
    set_mode(2'b00);
    c0 = acc_cnt;
    do_req(16'h0500, 1'b0, 1'b1);
    do_req(16'h0600, 1'b1, 1'b1);
    idle(1); #5;
    chk("R5 two reads per branch", acc_cnt, c0 + 2);
    @(negedge clk); rsv_valid = 1'b1; rsv_taken = 1'b1; #5;
    @(negedge clk); rsv_valid = 1'b0; #5;
    chk("R12 no read after idle resolve", fl_rd, 0);
    @(negedge clk); #5;
    chk("R12 counter unchanged", acc_cnt, c0 + 2);

    // R6 / R8: suppression on, not taken
    set_mode(2'b10);
    c0 = acc_cnt;
    do_req(16'h0700, 1'b0, 1'b1);
    req_valid = 1'b1; req_addr = 16'h0800; req_spec = 1'b1; #5;
    chk("R6 target accepted", req_ready, 1);
    chk("R6 target not read", fl_rd, 0);
    @(negedge clk); req_valid = 1'b0; req_spec = 1'b0;
    rsv_valid = 1'b1; rsv_taken = 1'b0;
    @(negedge clk); rsv_valid = 1'b0;
    all_rd = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #5; all_rd |= fl_rd; @(negedge clk);
    end
    chk("R8 no read after not-taken", all_rd, 0);
    #5;
    chk("R8 one read saved", acc_cnt, c0 + 1);

    // R7 / R11: suppression on, taken
    @(negedge clk);
    c0 = acc_cnt;
    req_valid = 1'b1; req_addr = 16'h0900; req_spec = 1'b1; #5;
    chk("R6 target parked", fl_rd, 0);
    @(negedge clk); req_addr = 16'h0A00; #5;
    chk("R11 second target blocked", req_ready, 0);
    @(negedge clk); req_valid = 1'b0; req_spec = 1'b0;
    rsv_valid = 1'b1; rsv_taken = 1'b1; #5;
    chk("R7 no read on strobe cycle", fl_rd, 0);
    @(negedge clk); rsv_valid = 1'b0;
    req_valid = 1'b1; req_addr = 16'h0B00; #5;
    chk("R7 target issued", fl_rd, 1);
    chk("R7 target address", fl_addr, 16'h0900);
    chk("R7 request deferred", req_ready, 0);
    exp_q.push_back(fdat(16'h0900));
    @(negedge clk); #5;
    chk("R7 request then accepted", fl_addr, 16'h0B00);
    exp_q.push_back(fdat(16'h0B00));
    @(negedge clk); req_valid = 1'b0;
    idle(1); #5;
    chk("R10 counts taken path", acc_cnt, c0 + 2);

    // R7 under one-wait suppression
    @(negedge clk); set_mode(2'b11);
    do_req(16'h0C00, 1'b1, 1'b0);
    rsv_valid = 1'b1; rsv_taken = 1'b1;
    @(negedge clk); rsv_valid = 1'b0; #5;
    chk("R7 one-wait target issued", fl_addr, 16'h0C00);
    exp_q.push_back(fdat(16'h0C00));
    @(negedge clk); #5;
    chk("R4 target wait cycle", rsp_valid, 0);
    @(negedge clk); #5;
    chk("R4 target data", rsp_valid, 1);

    // R10: counter wraps
    @(negedge clk); set_mode(2'b00);
    c0 = acc_cnt;
    all_rd = 1'b1;
    req_valid = 1'b1;
    for (int i = 0; i < 65536; i++) begin
      req_addr = 16'(i); #5;
      all_rd &= fl_rd;
      exp_q.push_back(fdat(16'(i)));
      @(negedge clk);
    end
    req_valid = 1'b0;
    idle(2); #5;
    chk("R10 all reads issued", all_rd, 1);
    chk("R10 counter wrapped", acc_cnt, c0);
    chk("R3 all responses returned", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule